// File: doc/BRIEF.md
# Half-Bridge Dead-Time Controller

This block sits between a switching controller and the two gate drivers of a half-bridge. It receives a high-side and a low-side command, and registers two gate outputs from them. The outputs are kept from conducting together. The block holds off each turn-on until a minimum number of clock cycles has gone by since the opposite gate output fell. A controller that already leaves a wider gap sees its timing passed through unchanged.

A 2-bit mode input selects the protection. The choices are overlap blanking only, a programmable minimum gap, a fixed maximum gap, or no protection at all. A cycle-count input sets the programmable gap. An enable input forces both gates off. Mode and count arrive as digital values. The block reads them only while both gates are low, so a change cannot disturb an interval that is already running.

Top module: `hb_deadtime`

## Requirements
- R1: While reset is asserted, both `gate_hi` and `gate_lo` are 0.
- R2: When `en` is sampled 0 at a clock edge, both gate outputs are 0 after that edge, whatever the commands are.
- R3: In mode 2'b00 (overlap blanking only), a gate follows its own command one edge later while the commands are exclusive. While both commands are 1, both gates are 0. Only mode 2'b11 ever drives both gates to 1 together.
- R4: In mode 2'b00, a controller gap of G ≥ 1 cycles between one command falling and the other rising appears unchanged at the gates. A simultaneous swap yields a gap of 1 cycle.
- R5: In mode 2'b01, after the opposite gate falls at edge k, a gate rises no earlier than edge k+D, where D is the effective count. A gate never rises in a protected mode while the opposite gate is high.
- R6: In mode 2'b01, a nonzero count below MIN_CNT (7 at defaults: 25 ns at 4 ns per cycle, rounded up) is raised to MIN_CNT. A count above MAX_CNT (50: 200 ns) is lowered to MAX_CNT.
- R7: In mode 2'b01, a count of 0 behaves like mode 2'b00.
- R8: In mode 2'b10, the minimum gap is MAX_CNT, whatever the count input is.
- R9: In mode 2'b11, each gate is its command registered by one edge, and both gates may be 1 together.
- R10: A gate falls at the first edge at which its command is sampled 0. Turn-off is never delayed.
- R11: Mode and count are taken only while both gates are 0. A mode change made while a gate is high has no effect until both gates are low.
- R12: In modes 2'b01 and 2'b10, a controller gap longer than the effective count passes unchanged: the gap seen at the gates equals max(G, D).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output enable; 0 forces both gates low |
| cmd_hi | input | 1 | High-side command from the controller |
| cmd_lo | input | 1 | Low-side command from the controller |
| mode | input | 2 | 00 blanking, 01 programmable, 10 maximum, 11 unprotected |
| dt_count | input | DT_W | Programmed minimum gap in clock cycles |
| gate_hi | output | 1 | High-side gate output |
| gate_lo | output | 1 | Low-side gate output |

## Verification
Every gate result is due one edge after the command that causes it. The exception is a delayed turn-on, which is due D edges after the opposite gate fell, or G edges when the controller gap is longer. The bench changes inputs on the falling clock edge and reads the outputs on later falling edges, so each rising edge lies cleanly between stimulus and sample. Gap tests count the low samples between the opposite gate falling and the gate rising. The bench compares that count with max(G, D, 1), computed from the mode, the count and the saturation bounds in the requirements.

// File: rtl/hb_deadtime.sv
module hb_deadtime #(
  parameter int CLK_NS = 4,
  parameter int MIN_NS = 25,
  parameter int MAX_NS = 200,
  parameter int DT_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            cmd_hi,
  input  logic            cmd_lo,
  input  logic [1:0]      mode,
  input  logic [DT_W-1:0] dt_count,
  output logic            gate_hi,
  output logic            gate_lo
);
  localparam int MIN_CNT = (MIN_NS + CLK_NS - 1) / CLK_NS;
  localparam int MAX_CNT = MAX_NS / CLK_NS;
  localparam logic [DT_W-1:0] MIN_V = DT_W'(MIN_CNT);
  localparam logic [DT_W-1:0] MAX_V = DT_W'(MAX_CNT);
  localparam logic [1:0] M_LOCK = 2'b00, M_PROG = 2'b01, M_MAX = 2'b10, M_OPEN = 2'b11;

  logic [1:0]      mode_q, mode_use;
  logic [DT_W-1:0] dt_q, dt_live, dt_use;
  logic [DT_W-1:0] since_lo, since_hi;
  logic            idle, hi_ok, lo_ok, hi_d, lo_d;

  assign idle = ~gate_hi & ~gate_lo;

  always_comb begin
    case (mode)
      M_PROG: begin
        if (dt_count == '0)        dt_live = '0;
        else if (dt_count < MIN_V) dt_live = MIN_V;
        else if (dt_count > MAX_V) dt_live = MAX_V;
        else                       dt_live = dt_count;
      end
      M_MAX:   dt_live = MAX_V;
      default: dt_live = '0;
    endcase
  end

  assign mode_use = idle ? mode    : mode_q;
  assign dt_use   = idle ? dt_live : dt_q;

  assign hi_ok = ~gate_lo & (((DT_W+1)'(since_lo) + (DT_W+1)'(1)) >= (DT_W+1)'(dt_use));
  assign lo_ok = ~gate_hi & (((DT_W+1)'(since_hi) + (DT_W+1)'(1)) >= (DT_W+1)'(dt_use));

  always_comb begin
    if (!en) begin
      hi_d = 1'b0;
      lo_d = 1'b0;
    end else if (mode_use == M_OPEN) begin
      hi_d = cmd_hi;
      lo_d = cmd_lo;
    end else begin
      hi_d = cmd_hi & ~cmd_lo & (gate_hi | hi_ok);
      lo_d = cmd_lo & ~cmd_hi & (gate_lo | lo_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi  <= 1'b0;
      gate_lo  <= 1'b0;
      mode_q   <= M_LOCK;
      dt_q     <= '0;
      since_lo <= MAX_V;
      since_hi <= MAX_V;
    end else begin
      gate_hi  <= hi_d;
      gate_lo  <= lo_d;
      mode_q   <= mode_use;
      dt_q     <= dt_use;
      since_lo <= gate_lo ? '0 : (since_lo >= MAX_V ? MAX_V : since_lo + DT_W'(1));
      since_hi <= gate_hi ? '0 : (since_hi >= MAX_V ? MAX_V : since_hi + DT_W'(1));
    end
  end

  // R2
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_hi && !gate_lo));
  // R10
  hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_hi |=> !gate_hi);
  // R10
  lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_lo |=> !gate_lo);
  // R3
  overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi && gate_lo) |-> (mode_q == M_OPEN));
  // R5
  hi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) && mode_q != M_OPEN) |-> !$past(gate_lo));
  // R5
  lo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_lo) && mode_q != M_OPEN) |-> !$past(gate_hi));
endmodule

// File: tb/test_hb_deadtime.sv
module test_hb_deadtime;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cmd_hi = 1'b0, cmd_lo = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] dt_count = 8'd0;
  logic gate_hi, gate_lo;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hb_deadtime i_hb_deadtime (
    .clk(clk), .rst_n(rst_n), .en(en), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .mode(mode), .dt_count(dt_count), .gate_hi(gate_hi), .gate_lo(gate_lo));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(logic [1:0] m, logic [7:0] c);
    @(negedge clk);
    cmd_hi = 1'b0; cmd_lo = 1'b0; en = 1'b1;
    repeat (60) @(negedge clk);
    mode = m; dt_count = c;
  endtask

  task automatic gap_hi(string req, logic [1:0] m, logic [7:0] c, int g, int exp);
    int gap = -1;
    settle(m, c);
    cmd_lo = 1'b1;
    repeat (4) @(negedge clk);
    cmd_lo = 1'b0;
    if (g == 0) cmd_hi = 1'b1;
    for (int i = 1; i <= 120; i++) begin
      @(negedge clk);
      if (i == 1) chk({req, " lo fell"}, int'(gate_lo), 0);
      if (gate_hi) begin gap = i - 1; break; end
      if (i == g) cmd_hi = 1'b1;
    end
    chk(req, gap, exp);
    cmd_hi = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 hi", int'(gate_hi), 0);
    chk("R1 lo", int'(gate_lo), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_blanking;
    settle(2'b00, 8'd0);
    cmd_hi = 1'b1;
    @(negedge clk); chk("R3 hi follows", int'(gate_hi), 1);
    cmd_lo = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 overlap hi", int'(gate_hi), 0);
      chk("R3 overlap lo", int'(gate_lo), 0);
    end
    cmd_hi = 1'b0;
    @(negedge clk); chk("R3 lo after overlap", int'(gate_lo), 1);
    cmd_lo = 1'b0;
    @(negedge clk); chk("R10 lo off", int'(gate_lo), 0);
  endtask

  task automatic t_turnoff;
    settle(2'b10, 8'd0);
    cmd_hi = 1'b1;
    repeat (2) @(negedge clk); chk("R10 hi on", int'(gate_hi), 1);
    cmd_hi = 1'b0;
    @(negedge clk); chk("R10 hi off next edge", int'(gate_hi), 0);
  endtask

  task automatic t_open_enable;
    settle(2'b11, 8'd0);
    cmd_hi = 1'b1; cmd_lo = 1'b1;
    @(negedge clk);
    chk("R9 hi", int'(gate_hi), 1);
    chk("R9 lo overlap", int'(gate_lo), 1);
    en = 1'b0;
    @(negedge clk);
    chk("R2 hi", int'(gate_hi), 0);
    chk("R2 lo", int'(gate_lo), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R9 hi back", int'(gate_hi), 1);
    cmd_hi = 1'b0; cmd_lo = 1'b0;
  endtask

  task automatic t_hold;
    settle(2'b11, 8'd0);
    cmd_hi = 1'b1;
    repeat (2) @(negedge clk);
    mode = 2'b00;
    cmd_lo = 1'b1;
    @(negedge clk);
    chk("R11 held open lo", int'(gate_lo), 1);
    chk("R11 held open hi", int'(gate_hi), 1);
    settle(2'b00, 8'd0);
    cmd_hi = 1'b1;
    repeat (2) @(negedge clk);
    mode = 2'b11;
    cmd_lo = 1'b1;
    @(negedge clk);
    chk("R11 held blank hi", int'(gate_hi), 0);
    chk("R11 held blank lo", int'(gate_lo), 0);
    cmd_hi = 1'b0; cmd_lo = 1'b0;
  endtask

  initial begin
    t_reset();
    t_blanking();
    gap_hi("R4 gap 6", 2'b00, 8'd0, 6, 6);
    gap_hi("R4 swap", 2'b00, 8'd0, 0, 1);
    gap_hi("R5 count 20", 2'b01, 8'd20, 0, 20);
    gap_hi("R5 short ctrl gap", 2'b01, 8'd10, 4, 10);
    gap_hi("R12 long ctrl gap", 2'b01, 8'd10, 15, 15);
    gap_hi("R6 low clamp", 2'b01, 8'd3, 0, 7);
    gap_hi("R6 high clamp", 2'b01, 8'd200, 0, 50);
    gap_hi("R7 zero swap", 2'b01, 8'd0, 0, 1);
    gap_hi("R7 zero gap 4", 2'b01, 8'd0, 4, 4);
    gap_hi("R8 max", 2'b10, 8'd5, 0, 50);
    gap_hi("R12 max long gap", 2'b10, 8'd5, 60, 60);
    t_turnoff();
    t_open_enable();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule